// File: doc/BRIEF.md
# Four-Channel Selectable-Priority DMA Arbiter

This block decides which of four DMA channels may own the transfer engine. Each channel raises a request bit. The arbiter grants exactly one of them with a one-hot grant vector. It holds that grant until the owning channel pulses a unit-complete signal. Only after that pulse does it pick again.

A small control/status register sets the arbitration policy. It holds a global enable, a two-bit ordering code and two sticky abort flags. The ordering code selects one of three fixed rankings or a rotating ranking. One abort flag is raised by a non-maskable interrupt input and the other by an address-error input. Either flag, or a cleared enable, removes any grant and blocks new ones until software clears the cause by writing the register.

Top module: `dmaarb_top`

## Requirements
- R1: After reset the grant vector is all zero and the status word reads 0x0000 (enable off, ordering code 00, both flags clear).
- R2: With ordering code 00 (status bits 9:8), the ranking from highest to lowest is channel 0, 1, 2, 3.
- R3: With ordering code 01, the ranking is channel 0, 2, 3, 1.
- R4: With ordering code 10, the ranking is channel 2, 0, 1, 3.
- R5: With ordering code 11, the ranking rotates: the channel that most recently signalled unit complete becomes the lowest and its successor (index plus one, modulo four) the highest. After reset, channel 0 is the highest.
- R6: The grant vector has at most one bit set. A grant stays unchanged while no unit-complete pulse arrives and arbitration is allowed.
- R7: When idle and allowed, a request seen at a clock edge is granted at that edge. A unit-complete pulse drops the grant at the edge that samples it, and the next pick happens at the following edge. A unit-complete pulse while nothing is granted has no effect.
- R8: While the enable (status bit 0) is 0, no grant is issued. Clearing it while a grant is held removes the grant at the next edge.
- R9: The NMI input sets status bit 1 at the next edge. The flag stays set until a register write carries 0 in bit 1, and writing 1 there leaves it set. While the flag is set, grants are removed and blocked.
- R10: The address-error input sets status bit 2 with the same sticky, write-0-to-clear and blocking behaviour as R9.
- R11: A register write loads the enable from bit 0 and the ordering code from bits 9:8. Every other status bit reads 0. A change of ordering code does not disturb a held grant.
- R12: When a flag's input is high in the same cycle as a write of 0 to that flag, the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per-channel request bits |
| done_i | input | 1 | Unit-complete pulse from the granted channel |
| nmi_i | input | 1 | Non-maskable interrupt, sets the NMI flag |
| addr_err_i | input | 1 | Address error, sets the address-error flag |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 16 | Register write data |
| gnt_o | output | 4 | One-hot grant |
| status_o | output | 16 | Register contents: bit 0 enable, bit 1 NMI flag, bit 2 address-error flag, bits 9:8 ordering code |

## Verification
Register writes and flag inputs show on the status word one edge after they are sampled. Grants also change at the edge that samples a request or a unit-complete pulse. The allow condition, however, comes from the registered status, so an abort or a write takes two edges to reach the grant.

A behavioural model in the bench follows these latencies and is compared with both outputs at every falling edge. Directed checks are taken a few nanoseconds after the edge that should produce each result, so they never sample across a register boundary.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;

   typedef enum logic [1:0] {
      PRI_ASC  = 2'b00,
      PRI_ZTTO = 2'b01,
      PRI_TZOT = 2'b10,
      PRI_ROT  = 2'b11
   } pri_mode_e;

   // channel holding a given rank (0 = highest) under a fixed ordering
   function automatic logic [1:0] fixed_rank(input pri_mode_e mode, input logic [1:0] rank);
      logic [1:0] ch;
      case (mode)
         PRI_ZTTO: case (rank)
                      2'd0: ch = 2'd0;
                      2'd1: ch = 2'd2;
                      2'd2: ch = 2'd3;
                      default: ch = 2'd1;
                   endcase
         PRI_TZOT: case (rank)
                      2'd0: ch = 2'd2;
                      2'd1: ch = 2'd0;
                      2'd2: ch = 2'd1;
                      default: ch = 2'd3;
                   endcase
         default:  ch = rank;
      endcase
      return ch;
   endfunction

endpackage

// File: rtl/dmaarb_opreg.sv
module dmaarb_opreg
   import dmaarb_pkg::*;
#(
   parameter int CFG_W   = 16,
   parameter int PRI_LSB = 8,
   parameter int EN_BIT  = 0,
   parameter int FLG_LSB = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic [CFG_W-1:0] wdata_i,
   input  logic             nmi_i,
   input  logic             ae_i,
   output logic             en_o,
   output pri_mode_e        pri_o,
   output logic [1:0]       flag_o,
   output logic [CFG_W-1:0] status_o
);
   localparam int FLG_N = 2;

   if (PRI_LSB + 2 > CFG_W) begin : g_bad_pri
      $error("ordering field does not fit in register");
   end
   if (FLG_LSB + FLG_N > PRI_LSB || EN_BIT >= FLG_LSB) begin : g_bad_flg
      $error("register fields overlap");
   end

   logic [FLG_N-1:0] set_in;
   assign set_in = {ae_i, nmi_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_o  <= 1'b0;
         pri_o <= PRI_ASC;
      end else if (we_i) begin
         en_o  <= wdata_i[EN_BIT];
         pri_o <= pri_mode_e'(wdata_i[PRI_LSB +: 2]);
      end
   end

   for (genvar f = 0; f < FLG_N; f++) begin : g_flag
      logic q;
      logic clr;
      assign clr = we_i && !wdata_i[FLG_LSB + f];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q <= 1'b0;
         else         q <= set_in[f] | (q & ~clr);
      end
      assign flag_o[f] = q;

      // f = 0 covers R9, f = 1 covers R10; set wins over clear (R12)
      p_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_in[f] |=> q);
      p_flag_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (q && !(we_i && !wdata_i[FLG_LSB + f])) |=> q);
   end

   always_comb begin
      status_o = '0;
      status_o[EN_BIT] = en_o;
      status_o[FLG_LSB +: FLG_N] = flag_o;
      status_o[PRI_LSB +: 2] = pri_o;
   end

endmodule

// File: rtl/dmaarb_pick.sv
module dmaarb_pick
   import dmaarb_pkg::*;
#(
   parameter int CH_N = 4,
   localparam int IDX_W = $clog2(CH_N)
) (
   input  logic [CH_N-1:0]  req_i,
   input  pri_mode_e        pri_i,
   input  logic [IDX_W-1:0] last_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             hit_o
);
   if (CH_N != 4) begin : g_bad_n
      $error("fixed orderings are defined for four channels only");
   end

   logic [IDX_W-1:0] ord [CH_N];

   for (genvar k = 0; k < CH_N; k++) begin : g_rank
      assign ord[k] = (pri_i == PRI_ROT) ? IDX_W'(last_i + IDX_W'(k + 1))
                                         : fixed_rank(pri_i, IDX_W'(k));
   end

   always_comb begin
      idx_o = '0;
      hit_o = 1'b0;
      for (int k = 0; k < CH_N; k++) begin
         if (!hit_o && req_i[ord[k]]) begin
            idx_o = ord[k];
            hit_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dmaarb_top.sv
module dmaarb_top
   import dmaarb_pkg::*;
#(
   parameter int CH_N    = 4,
   parameter int CFG_W   = 16,
   parameter int PRI_LSB = 8,
   localparam int IDX_W  = $clog2(CH_N)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CH_N-1:0]  req_i,
   input  logic             done_i,
   input  logic             nmi_i,
   input  logic             addr_err_i,
   input  logic             cfg_we_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   output logic [CH_N-1:0]  gnt_o,
   output logic [CFG_W-1:0] status_o
);
   logic             en;
   pri_mode_e        pri;
   logic [1:0]       flag;
   logic             allow;
   logic [IDX_W-1:0] pick_idx;
   logic             pick_hit;
   logic [CH_N-1:0]  gnt_q;
   logic [IDX_W-1:0] gidx_q;
   logic [IDX_W-1:0] last_q;

   dmaarb_opreg #(.CFG_W(CFG_W), .PRI_LSB(PRI_LSB), .EN_BIT(0), .FLG_LSB(1)) i_opreg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i),
      .wdata_i (cfg_wdata_i),
      .nmi_i   (nmi_i),
      .ae_i    (addr_err_i),
      .en_o    (en),
      .pri_o   (pri),
      .flag_o  (flag),
      .status_o(status_o)
   );

   dmaarb_pick #(.CH_N(CH_N)) i_pick (
      .req_i (req_i),
      .pri_i (pri),
      .last_i(last_q),
      .idx_o (pick_idx),
      .hit_o (pick_hit)
   );

   assign allow = en && (flag == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gnt_q  <= '0;
         gidx_q <= '0;
         last_q <= IDX_W'(CH_N - 1);
      end else if (!allow) begin
         gnt_q <= '0;
      end else if (gnt_q != '0) begin
         if (done_i) begin
            gnt_q  <= '0;
            last_q <= gidx_q;
         end
      end else if (pick_hit) begin
         gnt_q  <= CH_N'(1) << pick_idx;
         gidx_q <= pick_idx;
      end
   end

   assign gnt_o = gnt_q;

   p_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_q));
   p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_q != '0 && !done_i && allow) |=> gnt_q == $past(gnt_q));
   p_new_gnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_q != '0 && $past(gnt_q) == '0) |-> ($past(req_i) & gnt_q) != '0);
   p_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !allow |=> gnt_q == '0);

endmodule

// File: tb/test_dmaarb_top.sv
module test_dmaarb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  req = '0;
   logic        done = 1'b0, nmi = 1'b0, ae = 1'b0, we = 1'b0;
   logic [15:0] wd = '0;
   logic [3:0]  gnt;
   logic [15:0] status;

   int errors = 0;
   int checks = 0;

   // reference model state
   int m_en = 0, m_prio = 0, m_nmi = 0, m_ae = 0, m_gnt = -1, m_last = 3;

   always #10 clk = ~clk;

   dmaarb_top i_dmaarb_top (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done), .nmi_i(nmi),
      .addr_err_i(ae), .cfg_we_i(we), .cfg_wdata_i(wd), .gnt_o(gnt), .status_o(status)
   );

   function automatic int m_pick(int mode, logic [3:0] rq, int lst);
      int ord[$];
      case (mode)
         0: ord = '{0, 1, 2, 3};
         1: ord = '{0, 2, 3, 1};
         2: ord = '{2, 0, 1, 3};
         default: for (int k = 0; k < 4; k++) ord.push_back((lst + 1 + k) % 4);
      endcase
      foreach (ord[i]) if (rq[ord[i]]) return ord[i];
      return -1;
   endfunction

   always @(posedge clk) begin
      int n_gnt, n_last, allow;
      if (!rst_n) begin
         m_en = 0; m_prio = 0; m_nmi = 0; m_ae = 0; m_gnt = -1; m_last = 3;
      end else begin
         allow  = m_en && !m_nmi && !m_ae;
         n_gnt  = m_gnt;
         n_last = m_last;
         if (!allow) n_gnt = -1;
         else if (m_gnt >= 0) begin
            if (done) begin n_gnt = -1; n_last = m_gnt; end
         end else n_gnt = m_pick(m_prio, req, m_last);
         m_nmi = (nmi || (m_nmi && !(we && !wd[1]))) ? 1 : 0;
         m_ae  = (ae  || (m_ae  && !(we && !wd[2]))) ? 1 : 0;
         if (we) begin m_en = wd[0]; m_prio = wd[9:8]; end
         m_gnt = n_gnt; m_last = n_last;
      end
   end

   function automatic logic [15:0] m_status();
      return 16'((m_prio << 8) | (m_ae << 2) | (m_nmi << 1) | m_en);
   endfunction

   function automatic logic [3:0] m_gvec();
      return (m_gnt < 0) ? 4'b0000 : 4'(1 << m_gnt);
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-clock comparison with the model
   always @(negedge clk) begin
      if (rst_n) begin
         case (m_prio)
            0: chk("R2 grant vs model", 16'(gnt), 16'(m_gvec()));
            1: chk("R3 grant vs model", 16'(gnt), 16'(m_gvec()));
            2: chk("R4 grant vs model", 16'(gnt), 16'(m_gvec()));
            default: chk("R5 grant vs model", 16'(gnt), 16'(m_gvec()));
         endcase
         chk("R11 status vs model", status, m_status());
      end
   end

   task automatic cyc(logic [3:0] r, logic d, logic n, logic a, logic w, logic [15:0] dat);
      req = r; done = d; nmi = n; ae = a; we = w; wd = dat;
      @(posedge clk);
      #4;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req = '0; done = 0; nmi = 0; ae = 0; we = 0; wd = '0;
      repeat (3) @(posedge clk);
      #4 rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      do_reset();
      chk("R1 reset grant", 16'(gnt), 16'h0);
      chk("R1 reset status", status, 16'h0000);
      cyc(4'hF, 0, 0, 0, 0, 16'h0);      chk("R8 no grant when disabled", 16'(gnt), 16'h0);
      cyc(4'hF, 0, 0, 0, 1, 16'h0001);   chk("R11 enable written", status, 16'h0001);
      cyc(4'b1110, 0, 0, 0, 0, 16'h0);   chk("R2 ch1 wins", 16'(gnt), 16'h2);
      cyc(4'hF, 0, 0, 0, 0, 16'h0);      chk("R6 grant held", 16'(gnt), 16'h2);
      cyc(4'hF, 1, 0, 0, 0, 16'h0);      chk("R7 done drops grant", 16'(gnt), 16'h0);
      cyc(4'hF, 0, 0, 0, 0, 16'h0);      chk("R2 ch0 highest", 16'(gnt), 16'h1);
      cyc(4'hF, 0, 0, 0, 1, 16'h0101);   chk("R11 code change keeps grant", 16'(gnt), 16'h1);
      cyc(4'b1010, 1, 0, 0, 0, 16'h0);   chk("R7 done", 16'(gnt), 16'h0);
      cyc(4'b1010, 0, 0, 0, 0, 16'h0);   chk("R3 ch3 over ch1", 16'(gnt), 16'h8);
      cyc(4'h0, 1, 0, 0, 1, 16'h0201);   chk("R7 done", 16'(gnt), 16'h0);
      cyc(4'b0011, 0, 0, 0, 0, 16'h0);   chk("R4 ch0 over ch1", 16'(gnt), 16'h1);
      cyc(4'h0, 1, 0, 0, 0, 16'h0);
      cyc(4'b1010, 0, 0, 0, 0, 16'h0);   chk("R4 ch1 over ch3", 16'(gnt), 16'h2);
      cyc(4'h0, 1, 0, 0, 1, 16'h0301);
      cyc(4'hF, 0, 0, 0, 0, 16'h0);      chk("R5 after ch1 comes ch2", 16'(gnt), 16'h4);
      cyc(4'hF, 1, 0, 0, 0, 16'h0);
      cyc(4'h0, 1, 0, 0, 0, 16'h0);      chk("R7 idle done ignored", 16'(gnt), 16'h0);
      cyc(4'b1011, 0, 0, 0, 0, 16'h0);   chk("R5 ch3 after ch2", 16'(gnt), 16'h8);
      cyc(4'hF, 0, 1, 0, 0, 16'h0);      chk("R9 nmi flag set", status, 16'h0303);
      cyc(4'hF, 0, 0, 0, 0, 16'h0);      chk("R9 nmi blocks", 16'(gnt), 16'h0);
      cyc(4'hF, 0, 0, 0, 1, 16'h0303);   chk("R9 write 1 keeps flag", status, 16'h0303);
      cyc(4'hF, 0, 0, 0, 1, 16'h0301);   chk("R9 write 0 clears flag", status, 16'h0301);
      cyc(4'hF, 0, 0, 0, 0, 16'h0);      chk("R9 grant resumes", 16'(gnt), 16'h8);
      cyc(4'hF, 0, 0, 1, 0, 16'h0);      chk("R10 addr error flag set", status, 16'h0305);
      cyc(4'hF, 0, 0, 0, 0, 16'h0);      chk("R10 addr error blocks", 16'(gnt), 16'h0);
      cyc(4'h0, 0, 1, 1, 1, 16'h0301);   chk("R12 set beats clear", status, 16'h0307);
      cyc(4'h0, 0, 0, 0, 1, 16'h0301);   chk("R12 clear after", status, 16'h0301);
      cyc(4'b0100, 0, 0, 0, 0, 16'h0);   chk("R5 ch2 alone", 16'(gnt), 16'h4);
      cyc(4'b0100, 0, 0, 0, 1, 16'h0300);
      cyc(4'b0100, 0, 0, 0, 0, 16'h0);   chk("R8 disable drops grant", 16'(gnt), 16'h0);
      do_reset();
      chk("R1 second reset status", status, 16'h0000);
      cyc(4'h0, 0, 0, 0, 1, 16'h0301);
      cyc(4'hF, 0, 0, 0, 0, 16'h0);      chk("R5 ch0 highest after reset", 16'(gnt), 16'h1);
      for (int i = 0; i < 600; i++) begin
         logic w;
         logic [15:0] dat;
         w   = ($urandom % 8) == 0;
         dat = {6'b0, 2'($urandom), 7'b0, 1'(($urandom % 6) != 0)};
         cyc(4'($urandom), 1'(($urandom % 3) == 0), 1'(($urandom % 50) == 0),
             1'(($urandom % 60) == 0), w, dat);
      end
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule